// File: doc/BRIEF.md
# Pipelined Bubble-Tolerant Ones-Count Encoder

This block turns the sampled state of several parallel tapped delay lines into a binary fine-time code. All taps from all lines are treated as one pool of bits. The code is the number of taps that read one. Counting ones does not depend on tap order, so bubbles (isolated flipped taps near the propagation front) and taps that sample out of order cannot move the result the way a 0-to-1 edge search would.

The tap vector is registered through a two-flop synchronizer. It is then reduced by a registered adder tree. The first stage counts six-tap groups into 3-bit values; the last group is zero-padded. Each later stage adds pairs of partial sums and passes an odd leftover through unchanged. A valid bit follows each sample through every stage. One sample is accepted per clock, and the output appears after a fixed latency. With the default four lines of 200 cells, that latency is 11 cycles.

Top module: `ones_count_enc`

## Requirements
- R1: `count_o` equals the number of one bits in `taps_i` as sampled 11 clock edges earlier (default parameters: 2 synchronizer stages, 1 group stage, 8 pairwise stages).
- R2: `vld_o` equals `vld_i` as sampled 11 clock edges earlier, so each valid input produces exactly one valid output.
- R3: The count does not depend on where the ones sit. Bubbled thermometer codes and bit-reversed copies of a pattern give the population count of the pattern.
- R4: An all-zero tap vector yields 0 and an all-one vector yields 800. A single one at bit 0 or at bit 799 (the padded last group) yields 1.
- R5: While reset is asserted and for the first 10 edges after it, `vld_o` is 0 and `count_o` is 0.
- R6: `count_o` never exceeds the number of taps (800).
- R7: A new sample is accepted on every clock edge. Back-to-back valid samples produce back-to-back results in the same order.
- R8: Samples presented with `vld_i` low produce no valid output, whatever their tap pattern.
- R9: Line j of the tap pool occupies bits [j*200 +: 200] of `taps_i`. Every bit contributes equally, whatever line it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| taps_i | input | 800 | Raw taps of all delay lines, line j at bits [j*200 +: 200] |
| vld_i | input | 1 | Marks the current tap sample as a measurement |
| count_o | output | 10 | Number of ones in the sample taken 11 edges earlier |
| vld_o | output | 1 | Qualifies `count_o` |

## Verification
On every cycle, the bound checker compares `count_o` and `vld_o` against a latency-deep history of the input population count and input valid. It also keeps the count within the tap pool and holds the outputs at zero during the post-reset fill. Only the bench's scenarios can show behaviour tied to particular stimuli. These are bubbled and reversed thermometer codes, single taps in the padded last group, the saturated all-one pool, and long runs of invalid but busy tap patterns. Each one is scored item by item through the scoreboard, with the cycle of arrival checked.

// File: rtl/ones_enc_pkg.sv
`timescale 1ns/1ps
package ones_enc_pkg;

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // node count after lvl pairwise reductions
  function automatic int nodes_at(int n_in, int lvl);
    int n;
    n = n_in;
    for (int i = 0; i < lvl; i++) n = (n + 1) / 2;
    return n;
  endfunction

  function automatic int levels_for(int n_in);
    int n;
    int l;
    n = n_in;
    l = 0;
    while (n > 1) begin
      n = (n + 1) / 2;
      l++;
    end
    return l;
  endfunction

  function automatic int lvl_width(int lvl, int in_w, int out_w);
    return (lvl == 0) ? in_w : min_int(in_w + lvl, out_w);
  endfunction

  // bit offset of level lvl inside the flattened tree bus
  function automatic int lvl_off(int lvl, int n_in, int in_w, int out_w);
    int off;
    off = 0;
    for (int k = 0; k < lvl; k++) off += nodes_at(n_in, k) * lvl_width(k, in_w, out_w);
    return off;
  endfunction

endpackage

// File: rtl/tap_sync.sv
`timescale 1ns/1ps
module tap_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/group_popcount.sv
`timescale 1ns/1ps
module group_popcount #(
  parameter int N_BITS = 800,
  parameter int GRP    = 6,
  parameter int GRP_W  = 3,
  parameter int N_GRP  = 134
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_BITS-1:0]      bits_i,
  output logic [N_GRP*GRP_W-1:0] cnt_o
);
  localparam int PAD_BITS = N_GRP * GRP;

  logic [PAD_BITS-1:0] padded;
  assign padded = PAD_BITS'(bits_i);  // zero-pads the last group

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] sum_c;
    logic [GRP_W-1:0] sum_q;

    always_comb begin
      sum_c = '0;
      for (int b = 0; b < GRP; b++) sum_c += GRP_W'(padded[g*GRP + b]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q <= '0;
      else         sum_q <= sum_c;
    end

    assign cnt_o[g*GRP_W +: GRP_W] = sum_q;
  end
endmodule

// File: rtl/tree_level.sv
`timescale 1ns/1ps
module tree_level #(
  parameter int N_IN  = 134,
  parameter int W_IN  = 3,
  parameter int W_OUT = 4,
  localparam int N_OUT = (N_IN + 1) / 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN*W_IN-1:0]   d_i,
  output logic [N_OUT*W_OUT-1:0] q_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_node
    logic [W_OUT-1:0] sum_c;
    logic [W_OUT-1:0] sum_q;

    if (2*i + 1 < N_IN) begin : g_pair
      assign sum_c = W_OUT'(d_i[(2*i)*W_IN +: W_IN]) + W_OUT'(d_i[(2*i+1)*W_IN +: W_IN]);
    end else begin : g_odd
      assign sum_c = W_OUT'(d_i[(2*i)*W_IN +: W_IN]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q <= '0;
      else         sum_q <= sum_c;
    end

    assign q_o[i*W_OUT +: W_OUT] = sum_q;
  end
endmodule

// File: rtl/popcount_tree.sv
`timescale 1ns/1ps
module popcount_tree
  import ones_enc_pkg::*;
#(
  parameter int N_IN  = 134,
  parameter int IN_W  = 3,
  parameter int OUT_W = 10,
  localparam int LEVELS = levels_for(N_IN)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN*IN_W-1:0]  leaves_i,
  output logic [OUT_W-1:0]      sum_o
);
  localparam int BUS_W  = lvl_off(LEVELS + 1, N_IN, IN_W, OUT_W);
  localparam int LAST_W = lvl_width(LEVELS, IN_W, OUT_W);

  logic [BUS_W-1:0] tree_bus;

  assign tree_bus[0 +: N_IN*IN_W] = leaves_i;

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int NP = nodes_at(N_IN, l - 1);
    localparam int WP = lvl_width(l - 1, IN_W, OUT_W);
    localparam int NL = nodes_at(N_IN, l);
    localparam int WL = lvl_width(l, IN_W, OUT_W);
    localparam int OP = lvl_off(l - 1, N_IN, IN_W, OUT_W);
    localparam int OL = lvl_off(l, N_IN, IN_W, OUT_W);

    tree_level #(
      .N_IN (NP),
      .W_IN (WP),
      .W_OUT(WL)
    ) u_level (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (tree_bus[OP +: NP*WP]),
      .q_o   (tree_bus[OL +: NL*WL])
    );
  end

  assign sum_o = OUT_W'(tree_bus[lvl_off(LEVELS, N_IN, IN_W, OUT_W) +: LAST_W]);
endmodule

// File: rtl/ones_count_enc.sv
`timescale 1ns/1ps
module ones_count_enc
  import ones_enc_pkg::*;
#(
  parameter int LINES = 4,
  parameter int CELLS = 200,
  parameter int GRP   = 6,
  localparam int TAPS  = LINES * CELLS,
  localparam int CNT_W = $clog2(TAPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAPS-1:0]  taps_i,
  input  logic             vld_i,
  output logic [CNT_W-1:0] count_o,
  output logic             vld_o
);
  localparam int GRP_W   = $clog2(GRP + 1);
  localparam int N_GRP   = (TAPS + GRP - 1) / GRP;
  localparam int LEVELS  = levels_for(N_GRP);
  localparam int SYNC_ST = 2;
  localparam int LATENCY = SYNC_ST + 1 + LEVELS;

  logic [TAPS-1:0]        taps_sync;
  logic [N_GRP*GRP_W-1:0] grp_cnt;
  logic [LATENCY-1:0]     vld_pipe;

  tap_sync #(.W(TAPS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (taps_i),
    .q_o   (taps_sync)
  );

  group_popcount #(
    .N_BITS(TAPS),
    .GRP   (GRP),
    .GRP_W (GRP_W),
    .N_GRP (N_GRP)
  ) u_grp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bits_i(taps_sync),
    .cnt_o (grp_cnt)
  );

  popcount_tree #(
    .N_IN (N_GRP),
    .IN_W (GRP_W),
    .OUT_W(CNT_W)
  ) u_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .leaves_i(grp_cnt),
    .sum_o   (count_o)
  );

  // valid travels in lockstep with the data stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_pipe <= '0;
    else         vld_pipe <= {vld_pipe[LATENCY-2:0], vld_i};
  end

  assign vld_o = vld_pipe[LATENCY-1];
endmodule

// File: rtl/ones_count_enc_chk.sv
`timescale 1ns/1ps
module ones_count_enc_chk #(
  parameter int TAPS  = 800,
  parameter int CNT_W = 10,
  parameter int LAT   = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TAPS-1:0]  taps_i,
  input logic             vld_i,
  input logic [CNT_W-1:0] count_o,
  input logic             vld_o
);
  logic [CNT_W-1:0] pc_hist [LAT];
  logic [LAT-1:0]   vld_hist;
  logic [7:0]       fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) pc_hist[i] <= '0;
      vld_hist <= '0;
      fill_q   <= '0;
    end else begin
      pc_hist[0] <= CNT_W'($countones(taps_i));
      for (int i = 1; i < LAT; i++) pc_hist[i] <= pc_hist[i-1];
      vld_hist <= {vld_hist[LAT-2:0], vld_i};
      if (fill_q != 8'hff) fill_q <= fill_q + 8'd1;
    end
  end

  // R1
  count_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == pc_hist[LAT-1]);

  // R2
  vld_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == vld_hist[LAT-1]);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(TAPS));

  // R5
  reset_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(fill_q) < LAT - 1) |-> (!vld_o && count_o == '0));
endmodule

bind ones_count_enc ones_count_enc_chk #(
  .TAPS (TAPS),
  .CNT_W(CNT_W),
  .LAT  (LATENCY)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .taps_i (taps_i),
  .vld_i  (vld_i),
  .count_o(count_o),
  .vld_o  (vld_o)
);

// File: tb/ones_count_enc_tb.sv
`timescale 1ns/1ps
module ones_count_enc_tb;
  localparam int CLK_PERIOD = 2;
  localparam int LINES = 4;
  localparam int CELLS = 200;
  localparam int TAPS  = LINES * CELLS;
  localparam int LAT   = 11;  // 2 sync + 1 group + 8 pair stages
  localparam int WDOG  = 100000;

  typedef struct {
    int    cnt;
    int    cyc;
    string req;
  } exp_t;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [TAPS-1:0] taps_i = '0;
  logic            vld_i = 1'b0;
  logic [9:0]      count_o;
  logic            vld_o;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   run = 1'b0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  ones_count_enc u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .taps_i (taps_i),
    .vld_i  (vld_i),
    .count_o(count_o),
    .vld_o  (vld_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <%0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: present one sample at the falling edge
  task automatic send(logic [TAPS-1:0] t, bit v, string req);
    @(negedge clk_i);
    taps_i = t;
    vld_i  = v;
    if (v) sb_q.push_back('{cnt: $countones(t), cyc: cyc + LAT, req: req});
  endtask

  // monitor: every falling edge, valid must match a due item exactly
  always @(negedge clk_i) begin
    if (run) begin
      bit due;
      due = (sb_q.size() > 0) && (sb_q[0].cyc == cyc);
      check(vld_o == due, due ? {sb_q[0].req, "/R2 vld"} : "R8/R2 no vld", int'(vld_o), int'(due));
      if (due) begin
        exp_t e;
        e = sb_q.pop_front();
        check(int'(count_o) == e.cnt, {e.req, " count"}, int'(count_o), e.cnt);
        check(int'(count_o) <= TAPS, "R6 range", int'(count_o), TAPS);
      end
    end
  end

  function automatic logic [TAPS-1:0] thermo(int k0, int k1, int k2, int k3);
    logic [TAPS-1:0] t;
    int k[4];
    k = '{k0, k1, k2, k3};
    t = '0;
    for (int j = 0; j < LINES; j++)
      for (int b = 0; b < CELLS; b++)
        if (b < k[j]) t[j*CELLS + b] = 1'b1;
    return t;
  endfunction

  function automatic logic [TAPS-1:0] reverse(logic [TAPS-1:0] t);
    logic [TAPS-1:0] r;
    for (int i = 0; i < TAPS; i++) r[i] = t[TAPS-1-i];
    return r;
  endfunction

  function automatic logic [TAPS-1:0] rnd_vec();
    logic [TAPS-1:0] t;
    for (int i = 0; i < TAPS; i += 32) t[i +: 32] = $urandom;
    return t;
  endfunction

  initial begin
    logic [TAPS-1:0] t;
    // R5: reset state and post-reset fill
    repeat (3) @(negedge clk_i);
    check(vld_o == 1'b0 && count_o == '0, "R5 in reset", int'(count_o), 0);
    rst_ni = 1'b1;
    taps_i = {TAPS{1'b1}};
    for (int i = 0; i < LAT - 1; i++) begin
      @(negedge clk_i);
      check(vld_o == 1'b0 && count_o == '0, "R5 fill", int'(count_o), 0);
    end
    run = 1'b1;

    // R4 extremes, padded last group, R9 per-line placement
    send('0, 1'b1, "R4 all-zero");
    send({TAPS{1'b1}}, 1'b1, "R4 all-one");
    t = '0; t[0] = 1'b1;
    send(t, 1'b1, "R4 bit0");
    t = '0; t[TAPS-1] = 1'b1;
    send(t, 1'b1, "R4 bit799");
    for (int j = 0; j < LINES; j++) send(thermo(j == 0 ? 200 : 0, j == 1 ? 200 : 0,
                                               j == 2 ? 200 : 0, j == 3 ? 200 : 0), 1'b1, "R9 line");

    // R3: bubbled and reversed thermometer codes, back-to-back (R7)
    for (int k = 1; k < CELLS - 2; k += 13) begin
      t = thermo(k, k + 1, k, k + 2);
      t[k - 1] = 1'b0;
      t[k + 1] = 1'b1;            // bubble in line 0
      t[CELLS + k + 2] = 1'b1;    // stray one beyond front in line 1
      send(t, 1'b1, "R3 bubble");
      send(reverse(t), 1'b1, "R3 reversed");
    end

    // R8: busy taps while invalid, then valid again
    for (int i = 0; i < 20; i++) send(rnd_vec(), 1'b0, "R8");
    send(thermo(50, 60, 70, 80), 1'b1, "R8 resume");

    // R1/R7: random back-to-back stream with sparse gaps
    for (int i = 0; i < 200; i++) send(rnd_vec(), (i % 7) != 3, "R1 random");

    send('0, 1'b0, "idle");
    repeat (LAT + 4) @(negedge clk_i);
    check(sb_q.size() == 0, "R7 drained", sb_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule